// File: doc/BRIEF.md
# DRAM Self-Refresh Sequencer

This block moves an asynchronous-strobe DRAM into its self-refresh state when the host asks the system to sleep, and brings it back out when the host wakes it. It works beside the normal refresh scheduler. When a sleep is accepted it asks the scheduler for a burst refresh of every row. Once the scheduler reports that burst done, the block drops the column strobes and then the row strobe. This column-before-row order places the device in self-refresh.

The row strobe is then held low for at least the minimum self-refresh time. A wake request that arrives early is remembered and acted on as soon as that minimum has passed. On exit the strobes return high and stay high for one full precharge period. The block then asks the scheduler for a second all-row burst. The busy output stays high from sleep acceptance until that second burst is reported done.

Every time limit is given in nanoseconds and converted to clock cycles at elaboration. With the defaults (10 ns clock) this gives a 1-cycle column lead, a 10000-cycle minimum low time and a 9-cycle precharge. A refresh-style parameter (0 = burst, 1 = distributed) selects a 16 ms or 128 ms window. Elaboration checks that the refresh bursts before entry and after exit can start within that window.

Top module: `srs_seq`

## Requirements
- R1: Out of reset and whenever busy is low, ras_n, every cas_n bit and we_n are 1 and burst_req is 0.
- R2: A sleep_req sampled high while idle raises busy and burst_req in the next cycle. The strobes stay high until burst_done is sampled high.
- R3: After burst_done is sampled during the pre-entry burst, all cas_n bits go to 0 with ras_n still 1 for exactly the column-lead time (1 cycle by default). ras_n then falls while cas_n stays 0.
- R4: ras_n stays low for no fewer than the minimum self-refresh cycles (10000 by default). If a wake is already pending it stays low for exactly that many.
- R5: A wake_req seen at any point from sleep acceptance until the minimum is reached is held. The exit then starts in the first cycle after the minimum. A wake_req arriving later starts the exit in the next cycle.
- R6: On exit ras_n and all cas_n bits rise in the same cycle. They stay high for the precharge time (9 cycles by default) before burst_req rises again.
- R7: During the post-exit burst, busy and burst_req stay 1 until burst_done is sampled high. In the next cycle both are 0.
- R8: we_n is 1 in every cycle, including the entry and exit of self-refresh.
- R9: Three inputs are ignored outside their own phases. sleep_req is ignored while busy. wake_req is ignored while idle and during the exit recovery and post-exit burst, so it does not shorten a later sleep. burst_done is ignored unless burst_req is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sleep_req | input | 1 | Host request to enter self-refresh |
| wake_req | input | 1 | Host request to leave self-refresh |
| burst_done | input | 1 | Scheduler reports that the all-row burst has finished |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | NCAS | Column strobes, active low |
| we_n | output | 1 | Write enable, active low |
| busy | output | 1 | Sequence in progress |
| burst_req | output | 1 | Request for an all-row burst refresh |

## Verification
The hardest case to reach is a wake that lands in one of the narrow phases around the self-refresh period. These are the pre-entry burst, the single column-lead cycle, the last cycle before the minimum expires, and the recovery and post-exit burst, where a wake must be dropped. The stimulus times each wake pulse from the phase and elapsed count of its own behavioural model. It places pulses early, exactly on the boundary, late, and after exit. It then checks that the next sleep still waits out the full minimum.

// File: rtl/srs_pkg.sv
package srs_pkg;

   typedef enum logic [2:0] {
      ST_IDLE       = 3'd0,
      ST_PRE_BURST  = 3'd1,
      ST_CAS_LEAD   = 3'd2,
      ST_SELF       = 3'd3,
      ST_RECOVER    = 3'd4,
      ST_POST_BURST = 3'd5
   } srs_state_e;

   // Round a time in ns up to whole clock cycles, at least one.
   function automatic int ns_to_cyc(input int t_ns, input int clk_ns);
      int c;
      c = (t_ns + clk_ns - 1) / clk_ns;
      if (c < 1) c = 1;
      return c;
   endfunction

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      return m;
   endfunction

endpackage

// File: rtl/srs_timer.sv
module srs_timer #(
   parameter int TW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [TW-1:0] load_val,
   output logic          zero
);
   logic [TW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)            cnt <= '0;
      else if (load)         cnt <= load_val;
      else if (cnt != '0)    cnt <= cnt - 1'b1;
   end

   assign zero = (cnt == '0);
endmodule

// File: rtl/srs_wake_hold.sv
module srs_wake_hold (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic clr,
   input  logic wake_req,
   output logic pend
);
   always_ff @(posedge clk) begin
      if (!rst_n)               pend <= 1'b0;
      else if (clr)             pend <= 1'b0;
      else if (arm && wake_req) pend <= 1'b1;
   end
endmodule

// File: rtl/srs_ctrl.sv
module srs_ctrl
   import srs_pkg::*;
#(
   parameter int LEAD_CYC = 1,
   parameter int SELF_CYC = 16,
   parameter int REC_CYC  = 4,
   parameter int TW       = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sleep_req,
   input  logic          burst_done,
   input  logic          wake_seen,
   input  logic          tmr_zero,
   output srs_state_e    state,
   output logic          tmr_load,
   output logic [TW-1:0] tmr_val,
   output logic          wake_arm,
   output logic          exit_go
);
   srs_state_e nxt;

   always_comb begin
      nxt      = state;
      tmr_load = 1'b0;
      tmr_val  = '0;
      exit_go  = 1'b0;
      unique case (state)
         ST_IDLE: if (sleep_req) nxt = ST_PRE_BURST;
         ST_PRE_BURST: if (burst_done) begin
            nxt      = ST_CAS_LEAD;
            tmr_load = 1'b1;
            tmr_val  = TW'(LEAD_CYC - 1);
         end
         ST_CAS_LEAD: if (tmr_zero) begin
            nxt      = ST_SELF;
            tmr_load = 1'b1;
            tmr_val  = TW'(SELF_CYC - 1);
         end
         ST_SELF: if (tmr_zero && wake_seen) begin
            nxt      = ST_RECOVER;
            tmr_load = 1'b1;
            tmr_val  = TW'(REC_CYC - 1);
            exit_go  = 1'b1;
         end
         ST_RECOVER: if (tmr_zero) nxt = ST_POST_BURST;
         ST_POST_BURST: if (burst_done) nxt = ST_IDLE;
         default: nxt = ST_IDLE;
      endcase
   end

   assign wake_arm = (state == ST_PRE_BURST) || (state == ST_CAS_LEAD) || (state == ST_SELF);

   always_ff @(posedge clk) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= nxt;
   end
endmodule

// File: rtl/srs_pins.sv
module srs_pins
   import srs_pkg::*;
#(
   parameter int NCAS = 8
) (
   input  srs_state_e       state,
   output logic             ras_n,
   output logic [NCAS-1:0]  cas_n,
   output logic             we_n,
   output logic             busy,
   output logic             burst_req
);
   logic col_act;

   assign col_act   = (state == ST_CAS_LEAD) || (state == ST_SELF);
   assign ras_n     = (state != ST_SELF);
   assign we_n      = 1'b1;
   assign busy      = (state != ST_IDLE);
   assign burst_req = (state == ST_PRE_BURST) || (state == ST_POST_BURST);

   for (genvar i = 0; i < NCAS; i++) begin : g_cas
      assign cas_n[i] = ~col_act;
   end
endmodule

// File: rtl/srs_seq.sv
module srs_seq
   import srs_pkg::*;
#(
   parameter int CLK_NS        = 10,
   parameter int NCAS          = 8,
   parameter int CAS_LEAD_NS   = 5,
   parameter int SELF_MIN_NS   = 100_000,
   parameter int RECOVER_NS    = 84,
   parameter int REFRESH_STYLE = 0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            sleep_req,
   input  logic            wake_req,
   input  logic            burst_done,
   output logic            ras_n,
   output logic [NCAS-1:0] cas_n,
   output logic            we_n,
   output logic            busy,
   output logic            burst_req
);
   localparam int LEAD_CYC = ns_to_cyc(CAS_LEAD_NS, CLK_NS);
   localparam int SELF_CYC = ns_to_cyc(SELF_MIN_NS, CLK_NS);
   localparam int REC_CYC  = ns_to_cyc(RECOVER_NS, CLK_NS);
   localparam int MAX_CYC  = max3(LEAD_CYC, SELF_CYC, REC_CYC);
   localparam int TW       = $clog2(MAX_CYC + 1);

   // Elaboration-time parameter checks.
   if (NCAS < 1) begin : g_bad_ncas
      $error("srs_seq: NCAS must be at least 1");
   end
   if (CLK_NS < 1) begin : g_bad_clk
      $error("srs_seq: CLK_NS must be at least 1");
   end
   if (REFRESH_STYLE == 0) begin : g_win_burst
      localparam int WIN_CYC = 16_000_000 / CLK_NS;
      if (LEAD_CYC + 2 >= WIN_CYC || REC_CYC + 2 >= WIN_CYC) begin : g_bad_win
         $error("srs_seq: entry or exit latency exceeds the burst refresh window");
      end
   end else if (REFRESH_STYLE == 1) begin : g_win_dist
      localparam int WIN_CYC = 128_000_000 / CLK_NS;
      if (LEAD_CYC + 2 >= WIN_CYC || REC_CYC + 2 >= WIN_CYC) begin : g_bad_win
         $error("srs_seq: entry or exit latency exceeds the distributed refresh window");
      end
   end else begin : g_bad_style
      $error("srs_seq: REFRESH_STYLE must be 0 or 1");
   end

   srs_state_e     state;
   logic           tmr_load;
   logic [TW-1:0]  tmr_val;
   logic           tmr_zero;
   logic           wake_arm;
   logic           exit_go;
   logic           wake_pend;
   logic           wake_seen;

   assign wake_seen = wake_pend | wake_req;

   srs_ctrl #(
      .LEAD_CYC (LEAD_CYC),
      .SELF_CYC (SELF_CYC),
      .REC_CYC  (REC_CYC),
      .TW       (TW)
   ) i_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .sleep_req  (sleep_req),
      .burst_done (burst_done),
      .wake_seen  (wake_seen),
      .tmr_zero   (tmr_zero),
      .state      (state),
      .tmr_load   (tmr_load),
      .tmr_val    (tmr_val),
      .wake_arm   (wake_arm),
      .exit_go    (exit_go)
   );

   srs_timer #(.TW(TW)) i_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .zero     (tmr_zero)
   );

   srs_wake_hold i_wake (
      .clk      (clk),
      .rst_n    (rst_n),
      .arm      (wake_arm),
      .clr      (exit_go),
      .wake_req (wake_req),
      .pend     (wake_pend)
   );

   srs_pins #(.NCAS(NCAS)) i_pins (
      .state     (state),
      .ras_n     (ras_n),
      .cas_n     (cas_n),
      .we_n      (we_n),
      .busy      (busy),
      .burst_req (burst_req)
   );
endmodule

// File: rtl/srs_seq_chk.sv
module srs_seq_chk
   import srs_pkg::*;
#(
   parameter int CLK_NS      = 10,
   parameter int NCAS        = 8,
   parameter int SELF_MIN_NS = 100_000,
   parameter int RECOVER_NS  = 84
) (
   input logic            clk,
   input logic            rst_n,
   input logic            burst_done,
   input logic            ras_n,
   input logic [NCAS-1:0] cas_n,
   input logic            busy,
   input logic            burst_req
);
   localparam int SELF_CYC = ns_to_cyc(SELF_MIN_NS, CLK_NS);
   localparam int REC_CYC  = ns_to_cyc(RECOVER_NS, CLK_NS);

   int low_cnt;
   int hi_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         low_cnt <= 0;
         hi_cnt  <= REC_CYC;
      end else begin
         if (!ras_n) low_cnt <= low_cnt + 1;
         else        low_cnt <= 0;
         if (!ras_n)                 hi_cnt <= 0;
         else if (hi_cnt < REC_CYC)  hi_cnt <= hi_cnt + 1;
      end
   end

   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (ras_n && (&cas_n) && !burst_req));

   a_r3_col_before_row: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ras_n) |-> ($past(cas_n) == '0));

   a_r4_min_low: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ras_n) |-> (low_cnt >= SELF_CYC));

   a_r6_precharge: assert property (@(posedge clk) disable iff (!rst_n)
      (burst_req && $past(!ras_n || (cas_n != '1))) |-> (hi_cnt >= REC_CYC));

   a_r6_rise_together: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ras_n) |-> (cas_n == '1));

   a_r7_busy_release: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> ($past(burst_done) && $past(burst_req)));
endmodule

bind srs_seq srs_seq_chk #(
   .CLK_NS      (CLK_NS),
   .NCAS        (NCAS),
   .SELF_MIN_NS (SELF_MIN_NS),
   .RECOVER_NS  (RECOVER_NS)
) i_srs_seq_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .burst_done (burst_done),
   .ras_n      (ras_n),
   .cas_n      (cas_n),
   .busy       (busy),
   .burst_req  (burst_req)
);

// File: tb/test_srs_seq.sv
module test_srs_seq;
   localparam int NCAS     = 8;
   localparam int LEAD     = 1;
   localparam int SELF_MIN = 10000;
   localparam int REC      = 9;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            sleep_req = 1'b0;
   logic            wake_req = 1'b0;
   logic            burst_done = 1'b0;
   logic            ras_n;
   logic [NCAS-1:0] cas_n;
   logic            we_n;
   logic            busy;
   logic            burst_req;

   int n_cmp  = 0;
   int n_fail = 0;
   int cycles = 0;
   string scen = "R1";

   always #5 clk = ~clk;

   srs_seq i_srs_seq (
      .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .wake_req(wake_req),
      .burst_done(burst_done), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
      .busy(busy), .burst_req(burst_req)
   );

   // Behavioural reference: phase 0 idle, 1 first burst, 2 column lead,
   // 3 self-refresh, 4 recovery, 5 second burst.
   int m_phase = 0;
   int m_cnt   = 0;
   bit m_wpend = 0;

   always @(posedge clk) begin
      bit nw;
      if (!rst_n) begin
         m_phase = 0; m_cnt = 0; m_wpend = 0;
      end else begin
         nw = m_wpend | (wake_req && (m_phase >= 1 && m_phase <= 3));
         case (m_phase)
            0: if (sleep_req) m_phase = 1;
            1: if (burst_done) begin m_phase = 2; m_cnt = 0; end
            2: if (m_cnt == LEAD - 1) begin m_phase = 3; m_cnt = 0; end else m_cnt++;
            3: if (m_cnt >= SELF_MIN - 1 && (m_wpend || wake_req)) begin
                  m_phase = 4; m_cnt = 0; nw = 0;
               end else m_cnt++;
            4: if (m_cnt == REC - 1) m_phase = 5; else m_cnt++;
            5: if (burst_done) m_phase = 0;
            default: m_phase = 0;
         endcase
         m_wpend = nw;
      end
   end

   function automatic string ptag(int p);
      case (p)
         0: return "R1";
         1: return "R2";
         2: return "R3";
         3: return "R4";
         4: return "R6";
         default: return "R7";
      endcase
   endfunction

   task automatic cmp1(string tag, string nm, logic [NCAS-1:0] act, logic [NCAS-1:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s (scenario %s) %s act=%h exp=%h at cycle %0d", tag, scen, nm, act, exp, cycles);
      end
   endtask

   always @(negedge clk) begin
      cycles++;
      if (rst_n) begin
         cmp1(ptag(m_phase), "ras_n", NCAS'(ras_n), NCAS'(m_phase != 3));
         cmp1(ptag(m_phase), "cas_n", cas_n, (m_phase == 2 || m_phase == 3) ? '0 : '1);
         cmp1("R8", "we_n", NCAS'(we_n), NCAS'(1'b1));
         cmp1(ptag(m_phase), "busy", NCAS'(busy), NCAS'(m_phase != 0));
         cmp1(ptag(m_phase), "burst_req", NCAS'(burst_req), NCAS'(m_phase == 1 || m_phase == 5));
      end
      if (cycles > 150000) begin
         n_fail++;
         $display("FAIL watchdog expired act=running exp=finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
         $finish;
      end
   end

   task automatic tick(int n = 1);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wait_phase(int p);
      while (m_phase != p) tick();
   endtask

   task automatic pulse_sleep();
      sleep_req = 1'b1; tick(); sleep_req = 1'b0;
   endtask

   task automatic pulse_wake();
      wake_req = 1'b1; tick(); wake_req = 1'b0;
   endtask

   task automatic pulse_done();
      burst_done = 1'b1; tick(); burst_done = 1'b0;
   endtask

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(3);

      // R9: wake and burst_done in idle have no effect
      scen = "R9";
      pulse_wake(); pulse_done(); tick(3);

      // R2/R9: delayed burst_done, repeated sleep ignored; R5 early wake held
      scen = "R5";
      pulse_sleep(); tick(15);
      pulse_sleep(); tick(4);
      pulse_done();
      wait_phase(3); tick(50);
      pulse_wake();
      wait_phase(5); tick(6);
      pulse_done(); tick(4);

      // R4: wake long after the minimum
      scen = "R4";
      pulse_sleep(); pulse_done();
      wait_phase(3);
      while (m_cnt < SELF_MIN + 30) tick();
      pulse_wake();
      wait_phase(5); pulse_done(); tick(3);

      // R5: wake during the first burst, exit exactly at the minimum
      scen = "R5";
      pulse_sleep(); tick(2); pulse_wake(); tick(2); pulse_done();
      wait_phase(5); pulse_done(); tick(3);

      // R5: wake on the boundary cycle of the minimum
      pulse_sleep(); pulse_done();
      wait_phase(3);
      while (m_cnt < SELF_MIN - 1) tick();
      pulse_wake();
      wait_phase(4);
      // R9: wake during recovery and second burst is dropped
      scen = "R9";
      pulse_wake();
      wait_phase(5); pulse_wake(); tick(2); pulse_done(); tick(3);

      // R9: next sleep must still wait for its own wake; R3 with done held high
      scen = "R3";
      burst_done = 1'b1;
      pulse_sleep();
      wait_phase(3);
      burst_done = 1'b0;
      while (m_cnt < SELF_MIN + 5) tick();
      scen = "R9";
      pulse_wake();
      wait_phase(5); tick(2);
      scen = "R7";
      pulse_done(); tick(5);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
      $finish;
   end
endmodule